// File: doc/BRIEF.md
# Thread Barrier With Predicate Reduction

This block synchronises the thread groups of one thread block on any of sixteen independent barriers. Each arrival request names a barrier, carries a mask of the threads that arrive, their predicate bits and an operation mode. The barrier adds the arriving threads to its count. When the count reaches the target, the barrier releases. In the same step it delivers a reduction over the predicates of every thread that arrived in that round: a population count, a logical AND or a logical OR. An arrival may carry its own expected thread count. Without one, the barrier waits for the whole thread block. An arrive-only request adds its threads to the count but does not park the caller.

Each barrier is a small state machine with two states. SLOT_IDLE means no round is open. SLOT_FILL means a round is collecting arrivals. The transitions are:
- open: SLOT_IDLE to SLOT_FILL, on an accepted arrival that does not reach the target.
- complete: SLOT_FILL to SLOT_IDLE, on the arrival that reaches the target.
- instant: SLOT_IDLE to SLOT_IDLE, when a single arrival both opens and completes a round.
- stay: SLOT_FILL to SLOT_FILL, on an accepted arrival that does not reach the target.

A release clears the count and the accumulators in the same cycle, so the next arrival opens a fresh round. At most one arrival is presented per cycle.

Top module: `bar_sync_unit`

## Requirements
- R1: After reset, every barrier is in SLOT_IDLE. `rel_pulse`, `res_valid`, `err_mode` and `arr_hold` are 0.
- R2: An accepted arrival adds popcount(`arr_mask`) to the count of barrier `arr_bar_id`. If the count is now at or above the target, bit `arr_bar_id` of `rel_pulse` is high for exactly the next cycle, and the count returns to zero.
- R3: The target is latched by the arrival that opens a round. It is `arr_count` when `arr_use_count` is 1 and `arr_count` is nonzero. Otherwise it is BLOCK_THREADS. Count fields on later arrivals in the same round are ignored.
- R4: The sixteen barriers are independent. An arrival to one barrier never changes the count, target or accumulators of another.
- R5: With mode code 2'b00 (count), `res_popc` in the release cycle equals the number of threads, over all arrivals of the round, that had their mask bit set and an effective predicate of 1.
- R6: `res_flag` in the release cycle depends on the mode code of the completing arrival. With 2'b10 it is the AND of the effective predicates of all arriving threads. With 2'b01 it is their OR. With 2'b00 it is 0.
- R7: When `arr_pred_inv` is 1, every predicate bit of that arrival is inverted before it is reduced.
- R8: An arrival with `arr_nowait` = 1 adds its threads to the count but contributes nothing to the reduction. It acts as true for AND, false for OR and 0 for the count.
- R9: `arr_hold` is high for exactly one cycle after an accepted arrival with `arr_nowait` = 0 that does not complete its round. Otherwise it is low.
- R10: An arrival with mode code 2'b11 raises `err_mode` for the next cycle, causes no release, and leaves every barrier unchanged.
- R11: After a release, the next arrival to that barrier starts with a count of zero, a fresh target, a zero population count, an AND of true and an OR of false.
- R12: At most one bit of `rel_pulse` is high at a time. `res_valid` equals the OR of `rel_pulse`, and `res_bar` names the released barrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | An arrival request is present this cycle |
| arr_bar_id | input | ID_W (4) | Barrier number, 0 to 15 |
| arr_use_count | input | 1 | The request carries an expected thread count |
| arr_count | input | CNT_W (8) | Expected thread count for the round |
| arr_mask | input | LANES (32) | Threads of the group that arrive |
| arr_pred | input | LANES (32) | Predicate bit of each thread |
| arr_pred_inv | input | 1 | Invert the predicate bits before reduction |
| arr_mode | input | 2 | 00 count, 10 AND, 01 OR, 11 invalid |
| arr_nowait | input | 1 | Arrive-only request; no predicate, caller not held |
| rel_pulse | output | NUM_BAR (16) | One-cycle release per barrier |
| res_valid | output | 1 | The reduction result is valid this cycle |
| res_bar | output | ID_W (4) | Barrier that released |
| res_popc | output | ACC_W (8) | Count of true effective predicates over the round |
| res_flag | output | 1 | AND or OR result of the round |
| err_mode | output | 1 | The last request used the invalid mode code |
| arr_hold | output | 1 | The last request parks its caller until release |

## Verification
The hardest case to reach from the ports is a round built from many arrivals of different kinds. Such a round mixes arrive-only and waiting requests, sets the inverted predicate on only some of them, takes a rejected invalid-mode request partway through, and is interleaved with arrivals to other barriers, and its target comes from the first arrival only. Directed sequences build such rounds on purpose. A long stretch of random arrivals over all sixteen barriers then lets partial masks, random targets and occasional invalid codes overlap. A behavioural model tracks every barrier and checks every output in every cycle.

// File: rtl/bar_pkg.sv
package bar_pkg;
    typedef enum logic [1:0] {
        MODE_POPC = 2'b00,
        MODE_OR   = 2'b01,
        MODE_AND  = 2'b10,
        MODE_BAD  = 2'b11
    } red_mode_e;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_FILL = 1'b1
    } slot_state_e;
endpackage

// File: rtl/bar_popcount.sv
module bar_popcount #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/bar_slot.sv
module bar_slot
    import bar_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ACC_W  = 8,
    parameter int LANE_CW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit,
    input  logic [CNT_W-1:0]   first_tgt,
    input  logic [LANE_CW-1:0] add_thr,
    input  logic [LANE_CW-1:0] add_true,
    input  logic               no_false,
    input  logic               any_true,
    output logic               done,
    output logic [ACC_W-1:0]   pop_nxt,
    output logic               and_nxt,
    output logic               or_nxt
);
    slot_state_e       state_q, state_d;
    logic [ACC_W-1:0]  cnt_q, cnt_nxt;
    logic [CNT_W-1:0]  tgt_q, tgt_eff;
    logic [ACC_W-1:0]  pop_q;
    logic              and_q, or_q, fresh;

    always_comb begin
        fresh   = (state_q == SLOT_IDLE);
        tgt_eff = fresh ? first_tgt : tgt_q;
        cnt_nxt = (fresh ? '0 : cnt_q) + ACC_W'(add_thr);
        pop_nxt = (fresh ? '0 : pop_q) + ACC_W'(add_true);
        and_nxt = (fresh | and_q) & no_false;
        or_nxt  = (~fresh & or_q) | any_true;
        done    = hit && (cnt_nxt >= ACC_W'(tgt_eff));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: if (hit && !done) state_d = SLOT_FILL;
            SLOT_FILL: if (hit && done)  state_d = SLOT_IDLE;
            default:   state_d = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tgt_q <= '0;
            pop_q <= '0;
            and_q <= 1'b1;
            or_q  <= 1'b0;
        end else if (hit) begin
            if (done) begin
                cnt_q <= '0;
                pop_q <= '0;
                and_q <= 1'b1;
                or_q  <= 1'b0;
            end else begin
                cnt_q <= cnt_nxt;
                pop_q <= pop_nxt;
                and_q <= and_nxt;
                or_q  <= or_nxt;
                if (fresh) tgt_q <= tgt_eff;
            end
        end
    end
endmodule

// File: rtl/bar_result.sv
module bar_result
    import bar_pkg::*;
#(
    parameter int NUM_BAR = 16,
    parameter int ID_W    = 4,
    parameter int ACC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accepted,
    input  logic               bad,
    input  logic               nowait,
    input  logic [ID_W-1:0]    bar_id,
    input  logic [1:0]         mode,
    input  logic [NUM_BAR-1:0] done_vec,
    input  logic [ACC_W-1:0]   pop_sel,
    input  logic               and_sel,
    input  logic               or_sel,
    output logic [NUM_BAR-1:0] rel_pulse,
    output logic               res_valid,
    output logic [ID_W-1:0]    res_bar,
    output logic [ACC_W-1:0]   res_popc,
    output logic               res_flag,
    output logic               err_mode,
    output logic               arr_hold
);
    logic any_done, flag_d;

    always_comb begin
        any_done = |done_vec;
        flag_d   = 1'b0;
        unique case (red_mode_e'(mode))
            MODE_AND:  flag_d = and_sel;
            MODE_OR:   flag_d = or_sel;
            MODE_POPC: flag_d = 1'b0;
            MODE_BAD:  flag_d = 1'b0;
            default:   flag_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_pulse <= '0;
            res_valid <= 1'b0;
            res_bar   <= '0;
            res_popc  <= '0;
            res_flag  <= 1'b0;
            err_mode  <= 1'b0;
            arr_hold  <= 1'b0;
        end else begin
            rel_pulse <= done_vec;
            res_valid <= any_done;
            res_bar   <= any_done ? bar_id : '0;
            res_popc  <= any_done ? pop_sel : '0;
            res_flag  <= any_done ? flag_d : 1'b0;
            err_mode  <= bad;
            arr_hold  <= accepted && !any_done && !nowait;
        end
    end
endmodule

// File: rtl/bar_sync_unit.sv
module bar_sync_unit
    import bar_pkg::*;
#(
    parameter int NUM_BAR       = 16,
    parameter int LANES         = 32,
    parameter int BLOCK_THREADS = 128,
    localparam int ID_W    = $clog2(NUM_BAR),
    localparam int CNT_W   = $clog2(BLOCK_THREADS + 1),
    localparam int ACC_W   = $clog2(BLOCK_THREADS + LANES + 1),
    localparam int LANE_CW = $clog2(LANES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arr_valid,
    input  logic [ID_W-1:0]    arr_bar_id,
    input  logic               arr_use_count,
    input  logic [CNT_W-1:0]   arr_count,
    input  logic [LANES-1:0]   arr_mask,
    input  logic [LANES-1:0]   arr_pred,
    input  logic               arr_pred_inv,
    input  logic [1:0]         arr_mode,
    input  logic               arr_nowait,
    output logic [NUM_BAR-1:0] rel_pulse,
    output logic               res_valid,
    output logic [ID_W-1:0]    res_bar,
    output logic [ACC_W-1:0]   res_popc,
    output logic               res_flag,
    output logic               err_mode,
    output logic               arr_hold
);
    logic               bad, accepted;
    logic [LANES-1:0]   eff_pred, true_mask, false_mask;
    logic [LANE_CW-1:0] thr_cnt, true_cnt;
    logic [CNT_W-1:0]   first_tgt;
    logic [NUM_BAR-1:0] done_vec;
    logic [ACC_W-1:0]   pop_v [NUM_BAR];
    logic [NUM_BAR-1:0] and_v, or_v;

    always_comb begin
        bad        = arr_valid && (red_mode_e'(arr_mode) == MODE_BAD);
        accepted   = arr_valid && !bad;
        eff_pred   = arr_pred ^ {LANES{arr_pred_inv}};
        true_mask  = arr_nowait ? '0 : (arr_mask & eff_pred);
        false_mask = arr_nowait ? '0 : (arr_mask & ~eff_pred);
        first_tgt  = (arr_use_count && (arr_count != '0)) ? arr_count
                                                          : CNT_W'(BLOCK_THREADS);
    end

    bar_popcount #(.W(LANES), .CW(LANE_CW)) thr_pc_i  (.vec(arr_mask),  .cnt(thr_cnt));
    bar_popcount #(.W(LANES), .CW(LANE_CW)) true_pc_i (.vec(true_mask), .cnt(true_cnt));

    for (genvar b = 0; b < NUM_BAR; b++) begin : g_slot
        bar_slot #(.CNT_W(CNT_W), .ACC_W(ACC_W), .LANE_CW(LANE_CW)) slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (accepted && (arr_bar_id == ID_W'(b))),
            .first_tgt(first_tgt),
            .add_thr  (thr_cnt),
            .add_true (true_cnt),
            .no_false (~|false_mask),
            .any_true (|true_mask),
            .done     (done_vec[b]),
            .pop_nxt  (pop_v[b]),
            .and_nxt  (and_v[b]),
            .or_nxt   (or_v[b])
        );
    end

    bar_result #(.NUM_BAR(NUM_BAR), .ID_W(ID_W), .ACC_W(ACC_W)) result_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accepted (accepted),
        .bad      (bad),
        .nowait   (arr_nowait),
        .bar_id   (arr_bar_id),
        .mode     (arr_mode),
        .done_vec (done_vec),
        .pop_sel  (pop_v[arr_bar_id]),
        .and_sel  (and_v[arr_bar_id]),
        .or_sel   (or_v[arr_bar_id]),
        .rel_pulse(rel_pulse),
        .res_valid(res_valid),
        .res_bar  (res_bar),
        .res_popc (res_popc),
        .res_flag (res_flag),
        .err_mode (err_mode),
        .arr_hold (arr_hold)
    );
endmodule

// File: rtl/bar_sync_unit_chk.sv
module bar_sync_unit_chk #(
    parameter int NUM_BAR       = 16,
    parameter int LANES         = 32,
    parameter int BLOCK_THREADS = 128,
    localparam int ID_W  = $clog2(NUM_BAR),
    localparam int ACC_W = $clog2(BLOCK_THREADS + LANES + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               arr_valid,
    input logic [ID_W-1:0]    arr_bar_id,
    input logic [1:0]         arr_mode,
    input logic [NUM_BAR-1:0] rel_pulse,
    input logic               res_valid,
    input logic [ID_W-1:0]    res_bar,
    input logic [ACC_W-1:0]   res_popc,
    input logic               err_mode,
    input logic               arr_hold
);
    assert_rel_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rel_pulse));

    assert_valid_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == (|rel_pulse));

    assert_bar_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> rel_pulse[res_bar]);

    assert_rel_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(arr_valid) && ($past(arr_bar_id) == res_bar));

    assert_err_no_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_mode |-> !res_valid && !arr_hold);

    assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_mode |-> $past(arr_valid) && ($past(arr_mode) == 2'b11));

    assert_hold_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_hold |-> !res_valid && $past(arr_valid));

    assert_popc_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (int'(res_popc) <= BLOCK_THREADS + LANES - 1));
endmodule

bind bar_sync_unit bar_sync_unit_chk #(
    .NUM_BAR(NUM_BAR), .LANES(LANES), .BLOCK_THREADS(BLOCK_THREADS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_bar_id(arr_bar_id),
    .arr_mode(arr_mode), .rel_pulse(rel_pulse), .res_valid(res_valid),
    .res_bar(res_bar), .res_popc(res_popc), .err_mode(err_mode),
    .arr_hold(arr_hold)
);

// File: tb/bar_sync_unit_tb_top.sv
module bar_sync_unit_tb_top;
    localparam int NB = 16;
    localparam int LN = 32;
    localparam int BT = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arr_valid = 1'b0;
    logic [3:0]  arr_bar_id = '0;
    logic        arr_use_count = 1'b0;
    logic [7:0]  arr_count = '0;
    logic [31:0] arr_mask = '0;
    logic [31:0] arr_pred = '0;
    logic        arr_pred_inv = 1'b0;
    logic [1:0]  arr_mode = '0;
    logic        arr_nowait = 1'b0;
    logic [15:0] rel_pulse;
    logic        res_valid;
    logic [3:0]  res_bar;
    logic [7:0]  res_popc;
    logic        res_flag;
    logic        err_mode;
    logic        arr_hold;

    always #2 clk = ~clk;

    bar_sync_unit #(.NUM_BAR(NB), .LANES(LN), .BLOCK_THREADS(BT)) dut_i (
        .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_bar_id(arr_bar_id),
        .arr_use_count(arr_use_count), .arr_count(arr_count), .arr_mask(arr_mask),
        .arr_pred(arr_pred), .arr_pred_inv(arr_pred_inv), .arr_mode(arr_mode),
        .arr_nowait(arr_nowait), .rel_pulse(rel_pulse), .res_valid(res_valid),
        .res_bar(res_bar), .res_popc(res_popc), .res_flag(res_flag),
        .err_mode(err_mode), .arr_hold(arr_hold)
    );

    int total = 0;
    int bad = 0;
    string phase = "R1";

    // behavioural model state
    int m_cnt [NB];
    int m_tgt [NB];
    int m_pop [NB];
    bit m_and [NB];
    bit m_or  [NB];
    bit m_busy [NB];
    logic [15:0] e_rel = '0;
    bit e_valid = 0, e_flag = 0, e_err = 0, e_hold = 0;
    int e_bar = 0, e_popc = 0;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s (%s) act=%0d exp=%0d at %0t", tag, phase, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R2 rel_pulse", int'(rel_pulse), int'(e_rel));
        chk("R12 res_valid", int'(res_valid), int'(e_valid));
        chk("R10 err_mode", int'(err_mode), int'(e_err));
        chk("R9 arr_hold", int'(arr_hold), int'(e_hold));
        if (e_valid) begin
            chk("R12 res_bar", int'(res_bar), e_bar);
            chk("R5 res_popc", int'(res_popc), e_popc);
            chk("R6 res_flag", int'(res_flag), int'(e_flag));
        end
    endtask

    task automatic model(bit v, int id, bit uc, int c, logic [31:0] mk,
                         logic [31:0] pr, bit inv, int md, bit nw);
        logic [31:0] eff;
        e_rel = '0; e_valid = 0; e_flag = 0; e_err = 0; e_hold = 0;
        e_bar = 0; e_popc = 0;
        if (!v) return;
        if (md == 3) begin
            e_err = 1;
            return;
        end
        if (!m_busy[id]) begin
            m_cnt[id] = 0; m_pop[id] = 0; m_and[id] = 1; m_or[id] = 0;
            m_tgt[id] = (uc && c != 0) ? c : BT;
        end
        m_cnt[id] += $countones(mk);
        eff = inv ? ~pr : pr;
        if (!nw) begin
            m_pop[id] += $countones(mk & eff);
            if ((mk & ~eff) != 0) m_and[id] = 0;
            if ((mk & eff) != 0) m_or[id] = 1;
        end
        if (m_cnt[id] >= m_tgt[id]) begin
            e_rel[id] = 1'b1;
            e_valid = 1; e_bar = id; e_popc = m_pop[id];
            e_flag = (md == 2) ? m_and[id] : (md == 1) ? m_or[id] : 1'b0;
            m_busy[id] = 0;
        end else begin
            m_busy[id] = 1;
            e_hold = !nw;
        end
    endtask

    task automatic step(bit v, int id, bit uc, int c, logic [31:0] mk,
                        logic [31:0] pr, bit inv, int md, bit nw);
        @(negedge clk);
        compare();
        arr_valid = v; arr_bar_id = 4'(id); arr_use_count = uc; arr_count = 8'(c);
        arr_mask = mk; arr_pred = pr; arr_pred_inv = inv; arr_mode = 2'(md);
        arr_nowait = nw;
        model(v, id, uc, c, mk, pr, inv, md, nw);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0, '0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog expired (%s)", phase);
        summary();
    end

    initial begin
        for (int i = 0; i < NB; i++) begin
            m_busy[i] = 0; m_cnt[i] = 0; m_tgt[i] = BT; m_pop[i] = 0;
            m_and[i] = 1; m_or[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        phase = "R1 reset state";
        idle(3);

        phase = "R2 R5 default target, count mode";
        step(1, 3, 0, 0, 32'hFFFF_FFFF, 32'h0000_00FF, 0, 0, 0);
        step(1, 3, 0, 0, 32'hFFFF_FFFF, 32'hF0F0_F0F0, 0, 0, 0);
        step(1, 3, 0, 0, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 0);
        step(1, 3, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0);
        idle(2);

        phase = "R3 R6 explicit target, AND mode";
        step(1, 5, 1, 64, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 2, 0);
        step(1, 5, 1, 8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 2, 0);
        step(1, 5, 1, 64, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 0, 2, 0);
        step(1, 5, 1, 64, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 2, 0);
        step(1, 5, 1, 64, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 2, 0);
        idle(1);

        phase = "R6 OR mode with partial masks";
        for (int k = 0; k < 5; k++)
            step(1, 7, 1, 40, 32'h0000_00FF, (k == 3) ? 32'h0000_0100 : 32'h0, 0, 1, 0);
        for (int k = 0; k < 5; k++)
            step(1, 7, 1, 40, 32'h0000_00FF, (k == 4) ? 32'h0000_0010 : 32'h0, 0, 1, 0);

        phase = "R7 inverted predicate";
        step(1, 9, 1, 64, 32'hFFFF_FFFF, 32'h0000_000F, 1, 0, 0);
        step(1, 9, 1, 64, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 2, 0);
        step(1, 9, 1, 32, 32'hFFFF_FFFF, 32'h0000_0000, 1, 2, 0);

        phase = "R8 arrive-only mixed with waiting arrivals";
        step(1, 2, 1, 96, 32'hFFFF_FFFF, 32'h0, 0, 2, 1);
        step(1, 2, 1, 96, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 2, 0);
        step(1, 2, 1, 96, 32'hFFFF_FFFF, 32'h0, 0, 2, 1);
        step(1, 4, 1, 32, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1);

        phase = "R10 invalid mode mid-round";
        step(1, 6, 1, 64, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0);
        step(1, 6, 1, 64, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 3, 0);
        step(1, 11, 1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 3, 0);
        step(1, 6, 1, 64, 32'hFFFF_FFFF, 32'h0000_0003, 0, 0, 0);

        phase = "R4 interleaved barriers 0 and 15";
        step(1, 0, 1, 64, 32'hFFFF_FFFF, 32'h1, 0, 0, 0);
        step(1, 15, 1, 48, 32'h0000_FFFF, 32'hFFFF_FFFF, 0, 2, 0);
        step(1, 0, 1, 64, 32'hFFFF_FFFF, 32'h3, 0, 0, 0);
        step(1, 15, 1, 48, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 2, 0);

        phase = "R11 back-to-back rounds";
        step(1, 8, 1, 32, 32'hFFFF_FFFF, 32'h0, 0, 1, 0);
        step(1, 8, 1, 32, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 2, 0);
        step(1, 8, 1, 64, 32'hFFFF_FFFF, 32'h0, 0, 2, 0);
        step(1, 8, 1, 64, 32'hFFFF_FFFF, 32'h0, 0, 1, 0);
        idle(1);

        phase = "R12 random traffic";
        for (int k = 0; k < 3000; k++) begin
            int r = int'($urandom_range(0, 9));
            step(r != 0, int'($urandom_range(0, 15)), $urandom_range(0, 1) == 1,
                 int'($urandom_range(0, 128)), $urandom, $urandom,
                 $urandom_range(0, 1) == 1,
                 (r == 9) ? 3 : int'($urandom_range(0, 2)),
                 $urandom_range(0, 3) == 0);
        end
        idle(2);
        summary();
    end
endmodule